// File: doc/BRIEF.md
# Calendar Alarm Field Matcher

This block sits next to a calendar clock. On every tick of that clock it checks the current time against stored alarm settings. There are two separate alarm channels. Each channel holds six alarm bytes: seconds, minutes, hours, date, month and weekday. Each alarm byte is laid out like the clock byte it stands for, except for bit 7. Bit 7 selects whether that field takes part in the comparison. A channel matches when at least one of its fields is selected and every selected field equals the clock. There is no year field, so the year never affects a match.

Software loads the alarm bytes through a simple write port. The block evaluates a match only in a cycle where the tick strobe is high. Each match produces a one-cycle pulse and sets a sticky flag for that channel. The flag stays set until a write-one-to-clear input clears it. The clock fields are BCD values from the calendar counter, and the block compares them bit for bit.

Top module: `rtc_alarm_match`

## Requirements
- R1: While reset is high and in the first cycle after it, both flags and both pulses are 0, and every alarm byte reads as 0. With all enables clear, no channel can match until it is written.
- R2: The write address is `wr_addr_i[3]` = channel, `wr_addr_i[2:0]` = field. The field codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday. Field codes 6 and 7 change nothing.
- R3: Bit 7 of an alarm byte is the enable for its field. Only the low bits given by the clock byte width take part in the compare: 7 for seconds and minutes, 6 for hours and date, 5 for month, 3 for weekday. The alarm bits between that width and bit 7 are ignored.
- R4: A channel with no field enabled never pulses and never sets its flag.
- R5: Any subset of fields may be enabled. A field whose enable is clear has no effect on the match.
- R6: When `tick_i` is high and every enabled field matches, `match_pulse_o` of that channel is high for exactly the next cycle. Without a tick there is no pulse.
- R7: A channel's flag is set together with its pulse and stays set until cleared.
- R8: A 1 on `clr_i[c]` clears flag c at the next edge. A new match in the same cycle wins over the clear.
- R9: The two channels are independent. A write, a clear or a match on one channel leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Clock update strobe; when high, the compare is evaluated |
| sec_i | input | 7 | Clock seconds (BCD) |
| min_i | input | 7 | Clock minutes (BCD) |
| hour_i | input | 6 | Clock hours (BCD) |
| date_i | input | 6 | Clock day of month (BCD) |
| month_i | input | 5 | Clock month (BCD) |
| dow_i | input | 3 | Clock weekday |
| wr_en_i | input | 1 | Alarm byte write strobe |
| wr_addr_i | input | 4 | {channel, field code} |
| wr_data_i | input | 8 | Alarm byte; bit 7 is the field enable |
| clr_i | input | 2 | Per-channel write-one-to-clear for the flags |
| alarm_flag_o | output | 2 | Per-channel sticky alarm flag |
| match_pulse_o | output | 2 | Per-channel one-cycle match pulse |

## Verification
Four rules are checked on every cycle:
- a pulse always follows a tick;
- a pulse always comes with a set flag;
- a flag only rises together with a pulse, and holds unless it is cleared;
- after a clear, the flag is low unless a new match pulses.

Some behaviour can only be shown by the bench's scenarios, which compare against a model of the stored alarm bytes:
- which fields count and how the ignored alarm bits behave;
- that field codes 6 and 7 change nothing;
- that a channel with no enabled field stays silent;
- that the two channels are independent.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD = 6;
  localparam int BYTE_W = 8;
  localparam int FLD_W  = 3;

  typedef logic [BYTE_W-1:0] abyte_t;
  typedef logic [NFIELD-1:0][BYTE_W-1:0] fields_t;

  // compared bits per field: follows the width of the clock byte
  function automatic abyte_t cmp_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      4:       return 8'h1F;
      default: return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int CH_IDX = 0,
  parameter int CH_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [FLD_W-1:0] wr_fld_i,
  input  abyte_t           wr_data_i,
  output fields_t          alarm_o
);
  logic sel;
  assign sel = wr_en_i && (wr_ch_i == CH_W'(CH_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_o <= '0;
    end else if (sel) begin
      for (int i = 0; i < NFIELD; i++) begin
        if (wr_fld_i == FLD_W'(i)) alarm_o[i] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  fields_t alarm_i,
  input  fields_t clock_i,
  output logic    hit_o
);
  logic [NFIELD-1:0] en;
  logic [NFIELD-1:0] ok;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam abyte_t MSK = cmp_mask(i);
    assign en[i] = alarm_i[i][BYTE_W-1];
    assign ok[i] = !en[i] || ((alarm_i[i] & MSK) == (clock_i[i] & MSK));
  end

  assign hit_o = (|en) && (&ok);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + FLD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [6:0]        sec_i,
  input  logic [6:0]        min_i,
  input  logic [5:0]        hour_i,
  input  logic [5:0]        date_i,
  input  logic [4:0]        month_i,
  input  logic [2:0]        dow_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] alarm_flag_o,
  output logic [NUM_CH-1:0] match_pulse_o
);
  fields_t clock_f;
  assign clock_f[0] = {1'b0, sec_i};
  assign clock_f[1] = {1'b0, min_i};
  assign clock_f[2] = {2'b0, hour_i};
  assign clock_f[3] = {2'b0, date_i};
  assign clock_f[4] = {3'b0, month_i};
  assign clock_f[5] = {5'b0, dow_i};

  logic [CH_W-1:0]  wr_ch;
  logic [FLD_W-1:0] wr_fld;
  assign wr_ch  = wr_addr_i[ADDR_W-1:FLD_W];
  assign wr_fld = wr_addr_i[FLD_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fields_t alarm;
    logic    hit;

    rtc_alarm_regs #(.CH_IDX(c), .CH_W(CH_W)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en_i  (wr_en_i),
      .wr_ch_i  (wr_ch),
      .wr_fld_i (wr_fld),
      .wr_data_i(wr_data_i),
      .alarm_o  (alarm)
    );

    rtc_alarm_cmp u_cmp (
      .alarm_i(alarm),
      .clock_i(clock_f),
      .hit_o  (hit)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        match_pulse_o[c] <= 1'b0;
        alarm_flag_o[c]  <= 1'b0;
      end else begin
        match_pulse_o[c] <= tick_i && hit;
        alarm_flag_o[c]  <= (alarm_flag_o[c] && !clr_i[c]) || (tick_i && hit);
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic [NUM_CH-1:0] clr_i,
  input logic [NUM_CH-1:0] alarm_flag_o,
  input logic [NUM_CH-1:0] match_pulse_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    a_r6_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
      match_pulse_o[c] |-> $past(tick_i));
    a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
      match_pulse_o[c] |-> alarm_flag_o[c]);
    a_r7_rise_needs_pulse: assert property (@(posedge clk) disable iff (rst)
      $rose(alarm_flag_o[c]) |-> match_pulse_o[c]);
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
      (alarm_flag_o[c] && !clr_i[c]) |=> alarm_flag_o[c]);
    a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
      clr_i[c] |=> (!alarm_flag_o[c] || match_pulse_o[c]));
  end
endmodule

bind rtc_alarm_match rtc_alarm_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_i       (tick_i),
  .clr_i        (clr_i),
  .alarm_flag_o (alarm_flag_o),
  .match_pulse_o(match_pulse_o)
);

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic [6:0] sec_i = '0, min_i = '0;
  logic [5:0] hour_i = '0, date_i = '0;
  logic [4:0] month_i = '0;
  logic [2:0] dow_i = '0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] clr_i = '0;
  logic [1:0] alarm_flag_o, match_pulse_o;

  always #(CLK_P/2) clk = ~clk;

  rtc_alarm_match u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i), .date_i(date_i),
    .month_i(month_i), .dow_i(dow_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .clr_i(clr_i), .alarm_flag_o(alarm_flag_o), .match_pulse_o(match_pulse_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_al [2][6];
  logic [7:0] cf [6];
  bit   [1:0] m_flag;

  function automatic logic [7:0] msk(input int i);
    case (i)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      4:       return 8'h1F;
      default: return 8'h07;
    endcase
  endfunction

  function automatic bit mdl_hit(input int c);
    bit any = 0;
    bit ok  = 1;
    for (int i = 0; i < 6; i++) begin
      if (m_al[c][i][7]) begin
        any = 1;
        if ((m_al[c][i] & msk(i)) != (cf[i] & msk(i))) ok = 0;
      end
    end
    return any && ok;
  endfunction

  task automatic chk(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit [1:0] clr, input bit we,
                      input logic [3:0] wa, input logic [7:0] wd, input string tag);
    bit [1:0] ep, ef;
    @(negedge clk);
    tick_i = tk; clr_i = clr; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    sec_i = cf[0][6:0]; min_i = cf[1][6:0]; hour_i = cf[2][5:0];
    date_i = cf[3][5:0]; month_i = cf[4][4:0]; dow_i = cf[5][2:0];
    for (int c = 0; c < 2; c++) begin
      ep[c] = tk && mdl_hit(c);
      ef[c] = ep[c] || (m_flag[c] && !clr[c]);
    end
    if (we && wa[2:0] < 3'd6) m_al[wa[3]][wa[2:0]] = wd;
    @(posedge clk); #1;
    for (int c = 0; c < 2; c++) begin
      chk($sformatf("%s ch%0d pulse", tag, c), match_pulse_o[c], ep[c]);
      chk($sformatf("%s ch%0d flag", tag, c), alarm_flag_o[c], ef[c]);
    end
    m_flag = ef;
  endtask

  task automatic rand_clock();
    for (int i = 0; i < 6; i++) cf[i] = 8'($urandom) & msk(i);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int c = 0; c < 2; c++) for (int i = 0; i < 6; i++) m_al[c][i] = '0;
    m_flag = '0;
    rand_clock();
    tick_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset flag", |alarm_flag_o, 1'b0);
    chk("R1 reset pulse", |match_pulse_o, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R1/R4: nothing enabled, ticks with any clock never fire
    for (int k = 0; k < 6; k++) begin rand_clock(); step(1, 0, 0, 0, 0, "R1 R4 idle"); end
    cf[0] = 8'h00; step(1, 0, 0, 0, 0, "R4 zero clock");

    // R3: hour alarm 5 with spare bit 6 set, only hours enabled (R5)
    step(0, 0, 1, 4'h2, 8'hC5, "R2 write hour");
    rand_clock(); cf[2] = 8'h05;
    step(1, 0, 0, 0, 0, "R3 R5 hour match");
    chk("R3 directed pulse", match_pulse_o[0], 1'b1);
    chk("R9 other channel quiet", match_pulse_o[1], 1'b0);
    step(0, 0, 0, 0, 0, "R6 no tick no pulse");
    chk("R6 pulse one cycle", match_pulse_o[0], 1'b0);
    chk("R7 flag sticky", alarm_flag_o[0], 1'b1);
    cf[2] = 8'h06;
    step(1, 0, 0, 0, 0, "R3 hour mismatch");
    // R8 clear, then clear colliding with a set
    step(0, 2'b01, 0, 0, 0, "R8 clear");
    chk("R8 cleared", alarm_flag_o[0], 1'b0);
    cf[2] = 8'h05;
    step(1, 2'b01, 0, 0, 0, "R8 set beats clear");
    chk("R8 set wins", alarm_flag_o[0], 1'b1);
    // R2: field codes 6 and 7 change nothing
    step(0, 0, 1, 4'h6, 8'hFF, "R2 code6");
    step(0, 0, 1, 4'hF, 8'hFF, "R2 code7");
    step(1, 2'b11, 0, 0, 0, "R2 unchanged");
    // R5: channel 1 minutes and weekday; weekday spare bits set
    step(0, 0, 1, 4'h9, 8'h80 | 8'h42, "R5 write min");
    step(0, 0, 1, 4'hD, 8'hFB, "R3 write dow");
    rand_clock(); cf[1] = 8'h42; cf[5] = 8'h03;
    step(1, 0, 0, 0, 0, "R5 R3 ch1 match");
    chk("R5 ch1 pulse", match_pulse_o[1], 1'b1);
    cf[5] = 8'h04;
    step(1, 0, 0, 0, 0, "R5 dow mismatch");
    // R9: clear channel 1 only
    step(0, 2'b10, 0, 0, 0, "R9 clear one");

    // random mix
    for (int n = 0; n < 600; n++) begin
      bit tk, we;
      logic [1:0] cl;
      logic [3:0] wa;
      logic [7:0] wd;
      rand_clock();
      if ($urandom_range(1, 0) == 0) begin
        int c = $urandom_range(1, 0);
        for (int i = 0; i < 6; i++)
          if (m_al[c][i][7]) cf[i] = m_al[c][i] & msk(i);
      end
      tk = ($urandom_range(3, 0) != 0);
      cl = ($urandom_range(7, 0) == 0) ? 2'($urandom) : 2'b00;
      we = ($urandom_range(7, 0) == 0);
      wa = 4'($urandom);
      wd = 8'($urandom);
      step(tk, cl, we, wa, wd, "R3 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule